// File: doc/BRIEF.md
# Run-Length Compressed Trigger Capture Core

This block is the sampling core of an on-chip logic analyzer. It watches a parallel data bus on the system clock. It takes a sample only on clock edges where the qualifier input is high, so the qualifier acts as the valid strobe of the incoming sample stream. There is no ready signal and no back-pressure: capture never stalls, and a qualified sample that arrives while the core is idle or finished is simply not stored.

Samples are stored in a word-addressed RAM as run-length entries. Each word holds a data value in its upper bits and a repeat count in its low bits. A run of equal samples costs a single word. After it is armed, from a local pin or a host command, the core fills a circular pre-trigger window made of the words below a fixed trigger index. The first qualified sample that matches a masked pattern is stored at the trigger index. Later entries fill the words above it until memory is exhausted, and capture then stops.

Readout logic reads the RAM through a registered read port once `done` is high. Any word holding no entry reads as all zeros.

Top module: `rle_capture_core`

## Requirements
- R1: While reset is low and right after it, `armed`, `triggered` and `done` are 0 and every word reads as zero.
- R2: A high level on `arm_pin` or `arm_cmd` at a clock edge, while the core is idle or done, sets `armed` from the next cycle; an arm request while armed or triggered has no effect.
- R3: Only clock edges with `qual` high take a sample; changes on `din` while `qual` is low are neither stored nor break a run.
- R4: A word is `{data, count}` with the count in the low CNT_W bits. The first entry after arming goes to word 0, and consecutive qualified samples of one value share one word whose count equals the number of those samples.
- R5: A sample that differs from the current entry's value on the very next qualified edge opens a new entry at the next address with count 1.
- R6: When a count reaches 2^CNT_W-1, the next equal sample opens a new entry with count 1.
- R7: Before the trigger, entries use words 0 to TRIG_IDX-1 circularly: the entry after word TRIG_IDX-1 goes to word 0, overwriting it.
- R8: The first qualified sample while armed with `((din ^ trig_pattern) & trig_mask) == 0` is stored as a new entry of count 1 at word TRIG_IDX. From the next cycle `armed` is 0 and `triggered` is 1.
- R9: After the trigger, entries fill words TRIG_IDX+1 to DEPTH-1 with the same run-length rules. A sample that would need a word past DEPTH-1 is dropped, `done` rises on the next cycle, and no word changes until re-armed.
- R10: A word that holds no entry reads as zero data and zero count. Arming empties every word.
- R11: `rd_data` shows the word addressed by `rd_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| qual | input | 1 | Sample qualifier (valid strobe for `din`) |
| arm_pin | input | 1 | Local arm request |
| arm_cmd | input | 1 | Arm request from host command decoder |
| din | input | DATA_W | Sampled data bus |
| trig_pattern | input | DATA_W | Trigger compare value |
| trig_mask | input | DATA_W | Trigger compare mask, 1 = bit compared |
| rd_addr | input | ADDR_W | Readout word address |
| armed | output | 1 | Waiting for trigger |
| triggered | output | 1 | Trigger has fired |
| done | output | 1 | Post-trigger region full, capture stopped |
| rd_data | output | DATA_W+CNT_W | Registered readout word `{data, count}` |

## Verification
A wrong write pointer or a stuck run register shows up at the read port as a count that is off by one or as a value split across two words. It becomes visible one cycle after the word is addressed. A wrong state shows up on `armed`, `triggered` or `done` on the cycle after the qualified edge that should move it. Wrap-around and the end-of-memory stop are only reached after TRIG_IDX and DEPTH-TRIG_IDX entries respectively, so the bench drives distinct values long enough to reach both. It then reads back the words on either side of each boundary.

// File: rtl/rle_cap_pkg.sv
package rle_cap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_PRE  = 2'd1,
    CAP_POST = 2'd2,
    CAP_DONE = 2'd3
  } cap_state_e;
endpackage

// File: rtl/rle_cap_encoder.sv
module rle_cap_encoder #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic              force_new,
  input  logic [DATA_W-1:0] din,
  output logic              new_entry,
  output logic [CNT_W-1:0]  cnt_next
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic              run_open;
  logic [DATA_W-1:0] run_val;
  logic [CNT_W-1:0]  run_cnt;

  assign new_entry = !run_open || (din != run_val) || (run_cnt == CNT_MAX);
  assign cnt_next  = (new_entry || force_new) ? CNT_ONE : run_cnt + CNT_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_open <= 1'b0;
      run_val  <= '0;
      run_cnt  <= '0;
    end else if (clear) begin
      run_open <= 1'b0;
      run_cnt  <= '0;
    end else if (wr_en) begin
      run_open <= 1'b1;
      run_val  <= din;
      run_cnt  <= cnt_next;
    end
  end

  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt_next != '0)); // R4

  AST_RUN_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && run_open && din != run_val) |-> (cnt_next == CNT_ONE)); // R5

  AST_SAT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && run_open && run_cnt == CNT_MAX) |-> (cnt_next == CNT_ONE)); // R6
endmodule

// File: rtl/rle_cap_store.sv
module rle_cap_store #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W+CNT_W-1:0] wr_word,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W+CNT_W-1:0] rd_data
);
  localparam int WORD_W = DATA_W + CNT_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  used;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used <= '0;
    end else if (clear) begin
      used <= '0;
    end else if (wr_en) begin
      used[wr_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= used[rd_addr] ? mem[rd_addr] : '0;
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (used == '0)); // R10
endmodule

// File: rtl/rle_cap_ctrl.sv
module rle_cap_ctrl
  import rle_cap_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 16,
  parameter int TRIG_IDX = 6,
  parameter int ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qual,
  input  logic              arm_req,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] trig_pattern,
  input  logic [DATA_W-1:0] trig_mask,
  input  logic              new_entry,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              force_new,
  output logic              clear,
  output logic              armed,
  output logic              triggered,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST_A   = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] TRIG_A   = ADDR_W'(TRIG_IDX);
  localparam logic [ADDR_W-1:0] PRE_LAST = ADDR_W'(TRIG_IDX - 1);
  localparam logic [ADDR_W-1:0] ONE_A    = ADDR_W'(1);

  cap_state_e        state, nxt_state;
  logic [ADDR_W-1:0] ptr, nxt_ptr;
  logic              hit;

  assign hit = ((din ^ trig_pattern) & trig_mask) == '0;

  always_comb begin
    nxt_state = state;
    nxt_ptr   = ptr;
    wr_en     = 1'b0;
    wr_addr   = ptr;
    force_new = 1'b0;
    clear     = 1'b0;
    unique case (state)
      CAP_IDLE, CAP_DONE: begin
        if (arm_req) begin
          nxt_state = CAP_PRE;
          nxt_ptr   = PRE_LAST;
          clear     = 1'b1;
        end
      end
      CAP_PRE: begin
        if (qual) begin
          wr_en = 1'b1;
          if (hit) begin
            force_new = 1'b1;
            wr_addr   = TRIG_A;
            nxt_state = CAP_POST;
          end else if (new_entry) begin
            wr_addr = (ptr == PRE_LAST) ? '0 : ptr + ONE_A;
          end
          nxt_ptr = wr_addr;
        end
      end
      CAP_POST: begin
        if (qual) begin
          if (new_entry && ptr == LAST_A) begin
            nxt_state = CAP_DONE;
          end else begin
            wr_en = 1'b1;
            if (new_entry) wr_addr = ptr + ONE_A;
            nxt_ptr = wr_addr;
          end
        end
      end
      default: nxt_state = CAP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CAP_IDLE;
      ptr   <= '0;
    end else begin
      state <= nxt_state;
      ptr   <= nxt_ptr;
    end
  end

  assign armed     = (state == CAP_PRE);
  assign triggered = (state == CAP_POST) || (state == CAP_DONE);
  assign done      = (state == CAP_DONE);

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && triggered)); // R8

  AST_PRE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en && !force_new) |-> (wr_addr < TRIG_A)); // R7

  AST_TRIG_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    force_new |-> (wr_en && wr_addr == TRIG_A)); // R8

  AST_POST_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && wr_en) |-> (wr_addr >= TRIG_A)); // R9

  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en); // R9

  AST_NO_SAMPLE_UNQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |-> !wr_en); // R3
endmodule

// File: rtl/rle_capture_core.sv
module rle_capture_core #(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 3,
  parameter int DEPTH    = 16,
  parameter int TRIG_IDX = 6,
  parameter int ADDR_W   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    qual,
  input  logic                    arm_pin,
  input  logic                    arm_cmd,
  input  logic [DATA_W-1:0]       din,
  input  logic [DATA_W-1:0]       trig_pattern,
  input  logic [DATA_W-1:0]       trig_mask,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    armed,
  output logic                    triggered,
  output logic                    done,
  output logic [DATA_W+CNT_W-1:0] rd_data
);
  logic              wr_en, force_new, clear, new_entry;
  logic [ADDR_W-1:0] wr_addr;
  logic [CNT_W-1:0]  cnt_next;

  rle_cap_ctrl #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .TRIG_IDX(TRIG_IDX), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .qual(qual), .arm_req(arm_pin | arm_cmd),
    .din(din), .trig_pattern(trig_pattern), .trig_mask(trig_mask),
    .new_entry(new_entry), .wr_en(wr_en), .wr_addr(wr_addr),
    .force_new(force_new), .clear(clear),
    .armed(armed), .triggered(triggered), .done(done)
  );

  rle_cap_encoder #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en),
    .force_new(force_new), .din(din), .new_entry(new_entry), .cnt_next(cnt_next)
  );

  rle_cap_store #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_word({din, cnt_next}), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/rle_capture_core_tb.sv
`timescale 1ns/1ps
module rle_capture_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qual = 1'b0, arm_pin = 1'b0, arm_cmd = 1'b0;
  logic [7:0]  din = '0, trig_pattern = 8'hEE, trig_mask = 8'hFF;
  logic [3:0]  rd_addr = '0;
  logic        armed, triggered, done;
  logic [10:0] rd_data;
  int          n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rle_capture_core u_dut (
    .clk(clk), .rst_n(rst_n), .qual(qual), .arm_pin(arm_pin), .arm_cmd(arm_cmd),
    .din(din), .trig_pattern(trig_pattern), .trig_mask(trig_mask),
    .rd_addr(rd_addr), .armed(armed), .triggered(triggered), .done(done),
    .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_word(input string tag, input int a, input logic [7:0] d, input int c);
    @(negedge clk); rd_addr = 4'(a);
    @(posedge clk); #1;
    chk(tag, 32'(rd_data), 32'({d, 3'(c)}));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; qual = 1'b0;
    trig_pattern = 8'hEE; trig_mask = 8'hFF;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk); qual = 1'b1; din = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); qual = 1'b0; din = 8'h55;
    end
  endtask

  task automatic arm(input bit use_cmd);
    @(negedge clk);
    if (use_cmd) arm_cmd = 1'b1; else arm_pin = 1'b1;
    @(negedge clk); arm_cmd = 1'b0; arm_pin = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 armed after reset", 32'(armed), 0);
    chk("R1 triggered after reset", 32'(triggered), 0);
    chk("R1 done after reset", 32'(done), 0);
    chk_word("R1 R10 word0 empty", 0, 8'h00, 0);
    chk_word("R10 word15 empty", 15, 8'h00, 0);
  endtask

  task automatic t_runs();
    do_reset();
    arm(1'b0);
    chk("R2 armed by pin", 32'(armed), 1);
    idle(3);
    push(8'h0A); push(8'h0A);
    idle(2);
    push(8'h0A); push(8'h0B); push(8'h0C);
    idle(1);
    chk_word("R3 R4 run across qual gap", 0, 8'h0A, 3);
    chk_word("R5 next-cycle change word1", 1, 8'h0B, 1);
    chk_word("R5 next-cycle change word2", 2, 8'h0C, 1);
    chk_word("R10 R11 unused word3", 3, 8'h00, 0);
    arm(1'b1);
    chk("R2 arm ignored while armed", 32'(armed), 1);
    chk_word("R2 words kept after ignored arm", 0, 8'h0A, 3);
  endtask

  task automatic t_saturate();
    do_reset();
    arm(1'b1);
    chk("R2 armed by cmd", 32'(armed), 1);
    for (int i = 0; i < 9; i++) push(8'h3D);
    idle(1);
    chk_word("R6 saturated word", 0, 8'h3D, 7);
    chk_word("R6 overflow entry", 1, 8'h3D, 2);
  endtask

  task automatic t_wrap_trigger();
    do_reset();
    arm(1'b0);
    for (int v = 1; v <= 8; v++) push(8'(v));
    idle(1);
    chk_word("R7 wrap word0", 0, 8'h07, 1);
    chk_word("R7 wrap word1", 1, 8'h08, 1);
    chk_word("R7 oldest word2", 2, 8'h03, 1);
    chk("R8 still armed", 32'(armed), 1);
    push(8'hEE);
    idle(1);
    chk("R8 armed drops", 32'(armed), 0);
    chk("R8 triggered rises", 32'(triggered), 1);
    chk_word("R8 trigger word", 6, 8'hEE, 1);
    arm(1'b1);
    chk("R2 arm ignored while triggered", 32'(triggered), 1);
    push(8'hEE);
    for (int v = 16; v <= 24; v++) push(8'(v));
    idle(1);
    chk("R9 not done at last word", 32'(done), 0);
    chk_word("R9 post run at trigger", 6, 8'hEE, 2);
    chk_word("R9 first post word", 7, 8'h10, 1);
    push(8'h19);
    idle(1);
    chk("R9 done raised", 32'(done), 1);
    chk("R9 triggered kept", 32'(triggered), 1);
    push(8'h18); push(8'h77);
    idle(1);
    chk_word("R9 last word frozen", 15, 8'h18, 1);
    chk_word("R9 pre word untouched", 0, 8'h07, 1);
    arm(1'b0);
    chk("R10 rearm sets armed", 32'(armed), 1);
    chk("R10 rearm clears done", 32'(done), 0);
    chk_word("R10 rearm empties trigger word", 6, 8'h00, 0);
  endtask

  task automatic t_mask();
    do_reset();
    trig_pattern = 8'hA0; trig_mask = 8'hF0;
    arm(1'b1);
    push(8'h15); push(8'hA5);
    idle(1);
    chk("R8 masked match triggers", 32'(triggered), 1);
    chk_word("R8 masked trigger word", 6, 8'hA5, 1);
    chk_word("R4 pre entry kept", 0, 8'h15, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_runs();
    t_saturate();
    t_wrap_trigger();
    t_mask();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule